// File: doc/BRIEF.md
# Video DRAM Strobe-Side Cycle Mode Decoder

This block sits on the control side of a dual-port video DRAM that has a random-access port and a serial-access port. It watches the multiplexed address pins and the row strobe, column strobe, transfer/output-enable, two write enables and special-function control. From these it produces a latched row address, a latched column address, and a decoded cycle mode for each access. The decoded mode tells the rest of the memory controller whether the current cycle is a plain random access, a masked random access, a block write, a transfer in either direction between the array and the serial port, a refresh-type cycle or an unsupported special mode.

All pins are asynchronous to the system clock. Every pin passes through a multi-stage synchronizer, and strobe edges are found by comparing the synchronized value with its value one clock earlier. The five control levels are frozen when the row strobe falls. The column strobe fall then captures the column address and, for random cycles, chooses between ordinary access and block write. The block also derives the byte write enables and the read-data drive enable for the random port. It emits one-cycle pulses that mark each newly decoded mode and each column capture.

Top module: `vdram_mode_decoder`

## Requirements
- R1: On a row strobe fall, row_addr takes the synchronized address pins. On a column strobe fall in a random or transfer cycle, col_addr takes them. Each such update appears on the third rising clock edge after the pin change (two synchronizer stages plus the edge compare register).
- R2: The mode at a row strobe fall is encoded on cyc_mode and follows this priority. Column strobe low gives 6 (refresh). Otherwise special-function high gives 7 (special). Otherwise trg_n low gives a transfer: 4 (read transfer) when wel_n and weu_n are both high, else 5 (write transfer). Otherwise wel_n and weu_n both high give 1 (random), else 2 (random masked).
- R3: In a random cycle (mode 1, 2 or 3), special-function high at a column strobe fall sets cyc_mode to 3 (block write). Low sets it back to 1 or 2, depending on the mask state taken at the row strobe fall. Transfer modes are not changed by a column strobe fall.
- R4: wpb_en is high for a whole cycle whose mode at the row strobe fall was 2, and low for any other cycle.
- R5: While the synchronized row strobe is high, cyc_mode is 0 (idle) and wpb_en, we_lo, we_hi and dout_en are low.
- R6: In refresh (6) and special (7) cycles, a column strobe fall captures nothing: col_addr keeps its value and col_valid stays low.
- R7: mode_valid pulses for one clock each time cyc_mode takes a new decoded value: at every row strobe fall, and at a column strobe fall that changes the mode.
- R8: col_valid pulses for one clock at every column capture, including each repeated column strobe fall within one row cycle.
- R9: dout_en is high only when the mode is 1 or 2, a column has been captured in this row cycle, and the synchronized column strobe and trg_n are both low.
- R10: In modes 1, 2 and 3, after a column capture, a falling edge of wel_n sets we_lo and a falling edge of weu_n sets we_hi. A rising edge of the same pin clears the enable. Falls before the column capture, and falls in any other mode, are ignored.
- R11: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| trg_n | input | 1 | Transfer select / output enable, active low |
| wel_n | input | 1 | Lower-byte write enable, active low |
| weu_n | input | 1 | Upper-byte write enable, active low |
| dsf | input | 1 | Special-function select |
| addr_pin | input | ADDR_W | Multiplexed address pins |
| row_addr | output | ADDR_W | Latched row address |
| col_addr | output | ADDR_W | Latched column address |
| cyc_mode | output | 3 | Decoded cycle mode (encoding in R2, R3) |
| wpb_en | output | 1 | Write-per-bit masking active for this cycle |
| mode_valid | output | 1 | One-cycle pulse on a newly decoded mode |
| col_valid | output | 1 | One-cycle pulse on a column capture |
| we_lo | output | 1 | Lower-byte write enable to the array |
| we_hi | output | 1 | Upper-byte write enable to the array |
| dout_en | output | 1 | Random-port read data drive enable |

## Verification
The registered results (row_addr, col_addr, cyc_mode, wpb_en, we_lo, we_hi and both pulses) change on the third rising edge after an input changes. dout_en follows the synchronized levels one edge sooner, except for its column-captured term. The bench drives every input on a falling clock edge and waits five full cycles before it samples outputs on a falling edge, so every path has settled. One directed test samples exactly two and three edges after a row strobe fall to confirm the latency. The pulses are counted on rising edges into bench counters, and each step checks the change in those counts, so a pulse is never missed or counted twice.

// File: rtl/vdram_mode_pkg.sv
package vdram_mode_pkg;

   typedef enum logic [2:0] {
      CYC_IDLE        = 3'd0,
      CYC_RANDOM      = 3'd1,
      CYC_RANDOM_MASK = 3'd2,
      CYC_BLOCK_WR    = 3'd3,
      CYC_READ_XFER   = 3'd4,
      CYC_WRITE_XFER  = 3'd5,
      CYC_REFRESH     = 3'd6,
      CYC_SPECIAL     = 3'd7
   } cyc_mode_e;

   // bit positions inside the synchronized control bus
   localparam int CTL_RAS = 0;
   localparam int CTL_CAS = 1;
   localparam int CTL_TRG = 2;
   localparam int CTL_WEL = 3;
   localparam int CTL_WEU = 4;
   localparam int CTL_DSF = 5;
   localparam int CTL_W   = 6;

   // idle levels: strobes and enables high, special-function low
   localparam logic [CTL_W-1:0] CTL_IDLE = 6'b011111;

   function automatic logic is_random(cyc_mode_e m);
      return (m == CYC_RANDOM) || (m == CYC_RANDOM_MASK) || (m == CYC_BLOCK_WR);
   endfunction

   function automatic logic takes_column(cyc_mode_e m);
      return is_random(m) || (m == CYC_READ_XFER) || (m == CYC_WRITE_XFER);
   endfunction

endpackage

// File: rtl/vdram_sync.sv
module vdram_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("vdram_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("vdram_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
      end else begin
         chain_q[0] <= d;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/vdram_edge.sv
module vdram_edge #(
   parameter int               WIDTH   = 1,
   parameter bit               RISING  = 1'b0,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] edge_o
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= level;
   end

   generate
      if (RISING) begin : g_rise
         assign edge_o = level & ~prev_q;
      end else begin : g_fall
         assign edge_o = prev_q & ~level;
      end
   endgenerate

endmodule

// File: rtl/vdram_mode_class.sv
module vdram_mode_class
   import vdram_mode_pkg::*;
(
   input  logic      cas_n,
   input  logic      trg_n,
   input  logic      wel_n,
   input  logic      weu_n,
   input  logic      dsf,
   output cyc_mode_e mode
);

   logic both_we_high;
   assign both_we_high = wel_n & weu_n;

   always_comb begin
      if (!cas_n)      mode = CYC_REFRESH;
      else if (dsf)    mode = CYC_SPECIAL;
      else if (!trg_n) mode = both_we_high ? CYC_READ_XFER : CYC_WRITE_XFER;
      else             mode = both_we_high ? CYC_RANDOM : CYC_RANDOM_MASK;
   end

endmodule

// File: rtl/vdram_mode_decoder.sv
module vdram_mode_decoder
   import vdram_mode_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              trg_n,
   input  logic              wel_n,
   input  logic              weu_n,
   input  logic              dsf,
   input  logic [ADDR_W-1:0] addr_pin,
   output logic [ADDR_W-1:0] row_addr,
   output logic [ADDR_W-1:0] col_addr,
   output logic [2:0]        cyc_mode,
   output logic              wpb_en,
   output logic              mode_valid,
   output logic              col_valid,
   output logic              we_lo,
   output logic              we_hi,
   output logic              dout_en
);

   localparam int               BUS_W   = ADDR_W + CTL_W;
   localparam logic [BUS_W-1:0] BUS_RST = {{ADDR_W{1'b0}}, CTL_IDLE};

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("vdram_mode_decoder: ADDR_W must be at least 1");
      end
   endgenerate

   // ---------------- synchronization ----------------
   logic [BUS_W-1:0] pin_bus, sync_bus;

   assign pin_bus = {addr_pin, dsf, weu_n, wel_n, trg_n, cas_n, ras_n};

   vdram_sync #(
      .WIDTH  (BUS_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(BUS_RST)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_bus),
      .q    (sync_bus)
   );

   logic              ras_s, cas_s, trg_s, wel_s, weu_s, dsf_s;
   logic [ADDR_W-1:0] addr_s;

   assign ras_s  = sync_bus[CTL_RAS];
   assign cas_s  = sync_bus[CTL_CAS];
   assign trg_s  = sync_bus[CTL_TRG];
   assign wel_s  = sync_bus[CTL_WEL];
   assign weu_s  = sync_bus[CTL_WEU];
   assign dsf_s  = sync_bus[CTL_DSF];
   assign addr_s = sync_bus[BUS_W-1:CTL_W];

   // ---------------- edge detection ----------------
   logic [1:0] strobe_fall;   // [0] row, [1] column
   logic [1:0] we_fall;       // [0] lower, [1] upper
   logic [1:0] we_rise;

   vdram_edge #(.WIDTH(2), .RISING(1'b0), .RST_VAL(2'b11)) u_strobe_fall (
      .clk(clk), .rst_n(rst_n), .level({cas_s, ras_s}), .edge_o(strobe_fall)
   );

   vdram_edge #(.WIDTH(2), .RISING(1'b0), .RST_VAL(2'b11)) u_we_fall (
      .clk(clk), .rst_n(rst_n), .level({weu_s, wel_s}), .edge_o(we_fall)
   );

   vdram_edge #(.WIDTH(2), .RISING(1'b1), .RST_VAL(2'b11)) u_we_rise (
      .clk(clk), .rst_n(rst_n), .level({weu_s, wel_s}), .edge_o(we_rise)
   );

   // ---------------- classification ----------------
   cyc_mode_e row_mode;

   vdram_mode_class u_class (
      .cas_n(cas_s),
      .trg_n(trg_s),
      .wel_n(wel_s),
      .weu_n(weu_s),
      .dsf  (dsf_s),
      .mode (row_mode)
   );

   // ---------------- cycle state ----------------
   cyc_mode_e         mode_q;
   cyc_mode_e         page_mode;
   logic [ADDR_W-1:0] row_q, col_q;
   logic              wpb_q, col_done_q, mv_q, cv_q, we_lo_q, we_hi_q;

   always_comb begin
      if (dsf_s)      page_mode = CYC_BLOCK_WR;
      else if (wpb_q) page_mode = CYC_RANDOM_MASK;
      else            page_mode = CYC_RANDOM;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= CYC_IDLE;
         row_q      <= '0;
         col_q      <= '0;
         wpb_q      <= 1'b0;
         col_done_q <= 1'b0;
         mv_q       <= 1'b0;
         cv_q       <= 1'b0;
         we_lo_q    <= 1'b0;
         we_hi_q    <= 1'b0;
      end else begin
         mv_q <= 1'b0;
         cv_q <= 1'b0;
         if (ras_s) begin
            mode_q     <= CYC_IDLE;
            wpb_q      <= 1'b0;
            col_done_q <= 1'b0;
            we_lo_q    <= 1'b0;
            we_hi_q    <= 1'b0;
         end else if (strobe_fall[0]) begin
            mode_q     <= row_mode;
            row_q      <= addr_s;
            mv_q       <= 1'b1;
            wpb_q      <= (row_mode == CYC_RANDOM_MASK);
            col_done_q <= 1'b0;
            we_lo_q    <= 1'b0;
            we_hi_q    <= 1'b0;
         end else begin
            if (strobe_fall[1] && takes_column(mode_q)) begin
               col_q      <= addr_s;
               cv_q       <= 1'b1;
               col_done_q <= 1'b1;
               if (is_random(mode_q) && (page_mode != mode_q)) begin
                  mode_q <= page_mode;
                  mv_q   <= 1'b1;
               end
            end
            if (is_random(mode_q) && col_done_q) begin
               if (we_fall[0])      we_lo_q <= 1'b1;
               else if (we_rise[0]) we_lo_q <= 1'b0;
               if (we_fall[1])      we_hi_q <= 1'b1;
               else if (we_rise[1]) we_hi_q <= 1'b0;
            end
         end
      end
   end

   // ---------------- outputs ----------------
   logic read_mode;
   assign read_mode = (mode_q == CYC_RANDOM) || (mode_q == CYC_RANDOM_MASK);

   assign dout_en    = read_mode & col_done_q & ~cas_s & ~trg_s;
   assign row_addr   = row_q;
   assign col_addr   = col_q;
   assign cyc_mode   = mode_q;
   assign wpb_en     = wpb_q;
   assign mode_valid = mv_q;
   assign col_valid  = cv_q;
   assign we_lo      = we_lo_q;
   assign we_hi      = we_hi_q;

endmodule

// File: rtl/vdram_mode_decoder_chk.sv
module vdram_mode_decoder_chk
   import vdram_mode_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] row_addr,
   input logic [ADDR_W-1:0] col_addr,
   input logic [2:0]        cyc_mode,
   input logic              wpb_en,
   input logic              mode_valid,
   input logic              col_valid,
   input logic              we_lo,
   input logic              we_hi,
   input logic              dout_en
);

   logic mode_is_rand, mode_is_read, mode_takes_col;
   assign mode_is_rand   = (cyc_mode == 3'd1) || (cyc_mode == 3'd2) || (cyc_mode == 3'd3);
   assign mode_is_read   = (cyc_mode == 3'd1) || (cyc_mode == 3'd2);
   assign mode_takes_col = mode_is_rand || (cyc_mode == 3'd4) || (cyc_mode == 3'd5);

   // R1: the row address moves only together with a new-mode pulse
   assert_row_with_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row_addr) |-> mode_valid);

   // R8: the column address moves only together with a capture pulse
   assert_col_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(col_addr) |-> col_valid);

   // R6: a capture pulse never appears in refresh, special or idle modes
   assert_col_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      col_valid |-> mode_takes_col);

   // R7: a new-mode pulse always carries a non-idle mode
   assert_pulse_nonidle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_valid |-> (cyc_mode != 3'd0));

   // R9: read drive only in plain random modes
   assert_dout_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> mode_is_read);

   // R10: byte write enables only in random-port modes
   assert_we_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (we_lo || we_hi) |-> mode_is_rand);

   // R4: masking flag only in masked or block-write cycles
   assert_wpb_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wpb_en |-> ((cyc_mode == 3'd2) || (cyc_mode == 3'd3)));

   // R5: idle mode drives no enables
   assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_mode == 3'd0) |-> (!we_lo && !we_hi && !wpb_en && !dout_en));

endmodule

bind vdram_mode_decoder vdram_mode_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .row_addr  (row_addr),
   .col_addr  (col_addr),
   .cyc_mode  (cyc_mode),
   .wpb_en    (wpb_en),
   .mode_valid(mode_valid),
   .col_valid (col_valid),
   .we_lo     (we_lo),
   .we_hi     (we_hi),
   .dout_en   (dout_en)
);

// File: tb/vdram_mode_decoder_tb.sv
module vdram_mode_decoder_tb;

   localparam int AW = 9;
   localparam int NV = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ras_n = 1'b1, cas_n = 1'b1, trg_n = 1'b1;
   logic          wel_n = 1'b1, weu_n = 1'b1, dsf = 1'b0;
   logic [AW-1:0] addr_pin = '0;
   logic [AW-1:0] row_addr, col_addr;
   logic [2:0]    cyc_mode;
   logic          wpb_en, mode_valid, col_valid, we_lo, we_hi, dout_en;

   int checks = 0;
   int errors = 0;
   int mv_cnt = 0;
   int cv_cnt = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   vdram_mode_decoder #(.ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .trg_n(trg_n),
      .wel_n(wel_n), .weu_n(weu_n), .dsf(dsf), .addr_pin(addr_pin),
      .row_addr(row_addr), .col_addr(col_addr), .cyc_mode(cyc_mode),
      .wpb_en(wpb_en), .mode_valid(mode_valid), .col_valid(col_valid),
      .we_lo(we_lo), .we_hi(we_hi), .dout_en(dout_en)
   );

   // pulse counters: registered outputs read at the rising edge hold the previous cycle's value
   always @(posedge clk) begin
      if (mode_valid) mv_cnt <= mv_cnt + 1;
      if (col_valid)  cv_cnt <= cv_cnt + 1;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // vector: cas trg wel weu dsf_at_row dsf_at_col | row | col | mode_after_row | mode_after_col | col_captured
   localparam logic [39:0] VEC [NV] = '{
      {6'b111100, 9'h1A5, 9'h05A, 3'd1, 3'd1, 1'b1, 9'd0},
      {6'b110100, 9'h0F0, 9'h10F, 3'd2, 3'd2, 1'b1, 9'd0},
      {6'b111001, 9'h155, 9'h0AA, 3'd2, 3'd3, 1'b1, 9'd0},
      {6'b111101, 9'h1FF, 9'h001, 3'd1, 3'd3, 1'b1, 9'd0},
      {6'b101100, 9'h033, 9'h1CC, 3'd4, 3'd4, 1'b1, 9'd0},
      {6'b100000, 9'h100, 9'h0FF, 3'd5, 3'd5, 1'b1, 9'd0},
      {6'b101001, 9'h011, 9'h022, 3'd5, 3'd5, 1'b1, 9'd0},
      {6'b011100, 9'h0C3, 9'h13C, 3'd6, 3'd6, 1'b0, 9'd0},
      {6'b111110, 9'h07E, 9'h181, 3'd7, 3'd7, 1'b0, 9'd0},
      {6'b000010, 9'h0E1, 9'h1E1, 3'd6, 3'd6, 1'b0, 9'd0}
   };

   initial begin
      repeat (30000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int mv0, cv0;
      logic [AW-1:0] last_col;

      // R11: reset state
      tick(3);
      chk("R11", "mode in reset", int'(cyc_mode), 0);
      chk("R11", "outputs in reset", int'({row_addr, col_addr, wpb_en, mode_valid, col_valid, we_lo, we_hi, dout_en}), 0);
      rst_n = 1'b1;
      tick(5);
      chk("R11", "mode after reset", int'(cyc_mode), 0);
      chk("R5", "dout_en idle", int'(dout_en), 0);
      last_col = '0;

      // vector table walk
      for (int v = 0; v < NV; v++) begin
         logic [39:0] w;
         w = VEC[v];
         ras_n = 1'b1; cas_n = w[39]; trg_n = w[38]; wel_n = w[37]; weu_n = w[36];
         dsf = w[35]; addr_pin = w[33:25];
         tick(5);
         mv0 = mv_cnt;
         ras_n = 1'b0;
         tick(5);
         chk("R2", "mode at row fall", int'(cyc_mode), int'(w[15:13]));
         chk("R1", "row_addr", int'(row_addr), int'(w[33:25]));
         chk("R7", "mode pulses at row fall", mv_cnt - mv0, 1);
         chk("R4", "wpb_en", int'(wpb_en), (w[15:13] == 3'd2) ? 1 : 0);
         mv0 = mv_cnt; cv0 = cv_cnt;
         addr_pin = w[24:16]; dsf = w[34]; wel_n = 1'b1; weu_n = 1'b1;
         cas_n = 1'b0;
         tick(5);
         chk("R3", "mode after column fall", int'(cyc_mode), int'(w[12:10]));
         chk(w[9] ? "R8" : "R6", "column pulses", cv_cnt - cv0, int'(w[9]));
         chk(w[9] ? "R1" : "R6", "col_addr", int'(col_addr), w[9] ? int'(w[24:16]) : int'(last_col));
         chk("R7", "mode pulses at column fall", mv_cnt - mv0, (w[12:10] != w[15:13]) ? 1 : 0);
         chk("R9", "dout_en with trg high or transfer", int'(dout_en), 0);
         if (w[9]) last_col = w[24:16];
         ras_n = 1'b1; cas_n = 1'b1; dsf = 1'b0;
         tick(5);
         chk("R5", "mode after row rise", int'(cyc_mode), 0);
         chk("R5", "wpb_en after row rise", int'(wpb_en), 0);
      end

      // latency and read with page-mode columns
      trg_n = 1'b1; wel_n = 1'b1; weu_n = 1'b1; dsf = 1'b0; cas_n = 1'b1;
      addr_pin = 9'h123;
      tick(5);
      mv0 = mv_cnt;
      ras_n = 1'b0;
      tick(2);
      chk("R1", "mode two edges after row fall", int'(cyc_mode), 0);
      chk("R1", "row_addr two edges after row fall", int'(row_addr), 9'h0E1);
      tick(1);
      chk("R1", "mode three edges after row fall", int'(cyc_mode), 1);
      chk("R1", "row_addr three edges after row fall", int'(row_addr), 9'h123);
      chk("R7", "mode_valid high", int'(mode_valid), 1);
      tick(1);
      chk("R7", "mode_valid one cycle", int'(mode_valid), 0);
      trg_n = 1'b0;
      tick(5);
      chk("R9", "dout_en before column", int'(dout_en), 0);
      addr_pin = 9'h045; cas_n = 1'b0;
      tick(5);
      chk("R9", "dout_en read", int'(dout_en), 1);
      chk("R1", "col_addr read", int'(col_addr), 9'h045);
      cas_n = 1'b1;
      tick(5);
      chk("R9", "dout_en column high", int'(dout_en), 0);
      cv0 = cv_cnt; mv0 = mv_cnt;
      addr_pin = 9'h046; cas_n = 1'b0;
      tick(5);
      chk("R8", "page column pulse", cv_cnt - cv0, 1);
      chk("R8", "page col_addr", int'(col_addr), 9'h046);
      chk("R7", "no mode pulse on same mode", mv_cnt - mv0, 0);
      chk("R9", "dout_en page", int'(dout_en), 1);
      trg_n = 1'b1;
      tick(5);
      chk("R9", "dout_en trg high", int'(dout_en), 0);
      ras_n = 1'b1; cas_n = 1'b1;
      tick(5);

      // byte write enables
      ras_n = 1'b0;
      tick(5);
      wel_n = 1'b0;
      tick(5);
      chk("R10", "we_lo before column", int'(we_lo), 0);
      wel_n = 1'b1;
      tick(5);
      cas_n = 1'b0;
      tick(5);
      wel_n = 1'b0;
      tick(5);
      chk("R10", "we_lo after wel fall", int'(we_lo), 1);
      chk("R10", "we_hi untouched", int'(we_hi), 0);
      weu_n = 1'b0;
      tick(5);
      chk("R10", "we_hi after weu fall", int'(we_hi), 1);
      wel_n = 1'b1;
      tick(5);
      chk("R10", "we_lo after wel rise", int'(we_lo), 0);
      chk("R10", "we_hi holds", int'(we_hi), 1);
      ras_n = 1'b1; cas_n = 1'b1;
      tick(5);
      chk("R5", "we_hi after row rise", int'(we_hi), 0);
      weu_n = 1'b1;
      tick(5);

      // transfer cycle: no write enables, no read drive
      trg_n = 1'b0;
      tick(5);
      ras_n = 1'b0;
      tick(5);
      cas_n = 1'b0;
      tick(3);
      wel_n = 1'b0;
      tick(5);
      chk("R10", "we_lo in transfer", int'(we_lo), 0);
      chk("R9", "dout_en in transfer", int'(dout_en), 0);
      ras_n = 1'b1; cas_n = 1'b1; trg_n = 1'b1; wel_n = 1'b1;
      tick(5);

      // refresh-type cycle: write enable fall ignored
      cas_n = 1'b0;
      tick(5);
      ras_n = 1'b0;
      tick(5);
      chk("R2", "refresh mode", int'(cyc_mode), 6);
      wel_n = 1'b0;
      tick(5);
      chk("R10", "we_lo in refresh", int'(we_lo), 0);
      ras_n = 1'b1; cas_n = 1'b1; wel_n = 1'b1;
      tick(5);
      chk("R5", "idle at end", int'(cyc_mode), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule